// File: doc/BRIEF.md
# Hashtable Entry Aging Bitmap

This block holds one activity flag for every entry of a MAC lookup hashtable. Each time the match pipeline hits an entry it presents that entry's index, and the block sets the entry's flag. Software reads the flags through a word-wide CPU port. It then writes the words back with zeros to start a new observation window. Between two such passes it uses the flags to age or refresh per-entry counters.

A flag at 0 means the entry has not matched since its word was last written by the CPU. A flag at 1 means it matched at least once in that time. A hardware set is a two-cycle read-modify-write. The block forwards values internally so that a set which meets a CPU write, or a second set to the same word, is never lost.

Top module: `aging_bitmap`

## Requirements
- R1: After reset every flag is 0 and `cpu_rdata` is 0.
- R2: A hit index selects its word with its upper bits (index divided by `WORD_W`) and its bit position with its lower bits (index modulo `WORD_W`). Bit position 0 is the least significant bit of the word.
- R3: A hit sets exactly its own flag. A read presented two cycles after the hit cycle shows the flag. A read presented in the cycle right after the hit still shows the old value.
- R4: With `cpu_rd` high, `cpu_rdata` carries the addressed word after the next clock edge. With `cpu_rd` low, `cpu_rdata` holds its value.
- R5: A CPU write with no hit in flight to that word replaces the whole word with `cpu_wdata`. Writing 0 clears it.
- R6: Flags are never cleared except by a CPU write. A hit leaves every other flag and every other word unchanged.
- R7: Hits in consecutive cycles to the same word both keep their flags.
- R8: A CPU write to a word in the cycle after a hit to that word leaves the word at `cpu_wdata` ORed with the hit's flag.
- R9: A CPU write to a word in the same cycle as a hit to that word leaves the word at `cpu_wdata` ORed with the hit's flag.
- R10: A hit and a CPU write to different words in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | Match pipeline reports a hit this cycle |
| hit_index | input | IDX_W | Index of the matched hashtable entry |
| cpu_addr | input | ADDR_W | Word address for CPU read or write |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | WORD_W | CPU write data |
| cpu_rdata | output | WORD_W | Read data, valid one cycle after `cpu_rd` |

## Verification
The bench builds the block with `NUM_ENTRIES` = 1024 and `WORD_W` = 32, which gives 32 words and a 10-bit index. At that size the reset check can sweep every word. The lowest and highest index are reached directly. The forwarding paths are the same as at 8192 entries, and the directed tasks drive them: a second hit on the pending word, a CPU write on the pending word, and a CPU write in the same cycle as a hit.

// File: rtl/aging_bitmap.sv
module aging_bitmap #(
  parameter int NUM_ENTRIES = 8192,
  parameter int WORD_W      = 32,
  localparam int WORDS  = NUM_ENTRIES / WORD_W,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int IDX_W  = ADDR_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [IDX_W-1:0]  hit_index,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata
);

  logic [WORD_W-1:0] mem [WORDS];

  logic              p_valid;
  logic [ADDR_W-1:0] p_word;
  logic [WORD_W-1:0] p_mask;
  logic [WORD_W-1:0] p_data;

  logic [ADDR_W-1:0] hit_word;
  logic [BIT_W-1:0]  hit_bit;
  logic [WORD_W-1:0] hit_mask;
  logic              wr_meets_pend;
  logic [WORD_W-1:0] cpu_wval;
  logic [WORD_W-1:0] fwd_data;

  assign hit_word      = hit_index[IDX_W-1:BIT_W];
  assign hit_bit       = hit_index[BIT_W-1:0];
  assign hit_mask      = WORD_W'(1) << hit_bit;
  assign wr_meets_pend = p_valid && cpu_wr && (cpu_addr == p_word);
  assign cpu_wval      = cpu_wdata | (wr_meets_pend ? p_mask : '0);

  always_comb begin
    if (cpu_wr && cpu_addr == hit_word)
      fwd_data = cpu_wval;
    else if (p_valid && p_word == hit_word)
      fwd_data = p_data | p_mask;
    else
      fwd_data = mem[hit_word];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      p_valid   <= 1'b0;
      p_word    <= '0;
      p_mask    <= '0;
      p_data    <= '0;
      cpu_rdata <= '0;
    end else begin
      if (cpu_rd) cpu_rdata <= mem[cpu_addr];
      if (p_valid && !wr_meets_pend) mem[p_word] <= p_data | p_mask;
      if (cpu_wr) mem[cpu_addr] <= cpu_wval;
      p_valid <= hit_valid;
      if (hit_valid) begin
        p_word <= hit_word;
        p_mask <= hit_mask;
        p_data <= fwd_data;
      end
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && !(cpu_wr && cpu_addr == p_word)
    |=> (mem[$past(p_word)] & $past(p_mask)) == $past(p_mask)); // R3

  AST_WRITE_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && cpu_wr && cpu_addr == p_word
    |=> (mem[$past(cpu_addr)] & $past(p_mask)) == $past(p_mask)); // R8

  AST_ONLY_CPU_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr
    |=> (mem[$past(cpu_addr)] & $past(mem[cpu_addr])) == $past(mem[cpu_addr])); // R6

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata)); // R4

  AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> p_valid && $onehot0(p_mask) && p_mask != '0); // R2

endmodule

// File: tb/aging_bitmap_tb_top.sv
module aging_bitmap_tb_top;
  localparam int NE = 1024;
  localparam int WW = 32;
  localparam int NW = NE / WW;
  localparam int AW = $clog2(NW);
  localparam int IW = AW + $clog2(WW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hit_valid = 1'b0;
  logic [IW-1:0] hit_index = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [WW-1:0] cpu_wdata = '0;
  logic [WW-1:0] cpu_rdata;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  aging_bitmap #(.NUM_ENTRIES(NE), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_index(hit_index),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [WW-1:0] v);
    cpu_addr = AW'(a); cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic wr(input int a, input logic [WW-1:0] d);
    cpu_addr = AW'(a); cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic hit(input int idx);
    hit_index = IW'(idx); hit_valid = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [WW-1:0] v;
    check("R1 rdata", cpu_rdata, '0);
    for (int a = 0; a < NW; a++) begin
      rd(a, v);
      check("R1 word", v, '0);
    end
  endtask

  task automatic t_single;
    logic [WW-1:0] v;
    hit_index = IW'(3 * WW + 7); hit_valid = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0;
    rd(3, v);
    check("R3 early read old", v, '0);
    rd(3, v);
    check("R3 set visible", v, 32'h0000_0080);
    rd(2, v);
    check("R6 neighbour word", v, '0);
    rd(4, v);
    check("R6 next word", v, '0);
  endtask

  task automatic t_bounds;
    logic [WW-1:0] v;
    hit(0);
    rd(0, v);
    check("R2 index zero", v, 32'h0000_0001);
    hit(NE - 1);
    rd(NW - 1, v);
    check("R2 top index", v, 32'h8000_0000);
    hit(5 * WW + 31);
    rd(5, v);
    check("R2 msb of word 5", v, 32'h8000_0000);
  endtask

  task automatic t_read_hold;
    logic [WW-1:0] v;
    rd(3, v);
    cpu_addr = AW'(0);
    @(negedge clk);
    @(negedge clk);
    check("R4 rdata holds", cpu_rdata, 32'h0000_0080);
  endtask

  task automatic t_clear;
    logic [WW-1:0] v;
    wr(3, '0);
    rd(3, v);
    check("R5 clear", v, '0);
    wr(6, 32'hA5A5_0F0F);
    rd(6, v);
    check("R5 write word", v, 32'hA5A5_0F0F);
    hit(6 * WW + 4);
    rd(6, v);
    check("R6 set keeps bits", v, 32'hA5A5_0F1F);
  endtask

  task automatic t_b2b_same;
    logic [WW-1:0] v;
    hit_index = IW'(8 * WW + 1); hit_valid = 1'b1;
    @(negedge clk);
    hit_index = IW'(8 * WW + 30);
    @(negedge clk);
    hit_index = IW'(8 * WW + 12);
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
    rd(8, v);
    check("R7 three same-word hits", v, 32'h4000_1002);
  endtask

  task automatic t_b2b_diff;
    logic [WW-1:0] v;
    hit_index = IW'(9 * WW + 2); hit_valid = 1'b1;
    @(negedge clk);
    hit_index = IW'(10 * WW + 3);
    @(negedge clk);
    hit_valid = 1'b0;
    @(negedge clk);
    rd(9, v);
    check("R6 word 9 only own bit", v, 32'h0000_0004);
    rd(10, v);
    check("R6 word 10 only own bit", v, 32'h0000_0008);
  endtask

  task automatic t_write_after_hit;
    logic [WW-1:0] v;
    hit_index = IW'(12 * WW + 9); hit_valid = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0;
    wr(12, 32'h0000_0000);
    @(negedge clk);
    rd(12, v);
    check("R8 clear meets pending set", v, 32'h0000_0200);
  endtask

  task automatic t_write_with_hit;
    logic [WW-1:0] v;
    hit_index = IW'(14 * WW + 16); hit_valid = 1'b1;
    cpu_addr = AW'(14); cpu_wdata = 32'h0000_00F0; cpu_wr = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    rd(14, v);
    check("R9 write same cycle as hit", v, 32'h0001_00F0);
  endtask

  task automatic t_write_other;
    logic [WW-1:0] v;
    hit_index = IW'(16 * WW + 5); hit_valid = 1'b1;
    cpu_addr = AW'(17); cpu_wdata = 32'h1234_5678; cpu_wr = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    rd(16, v);
    check("R10 hit word", v, 32'h0000_0020);
    rd(17, v);
    check("R10 written word", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_bounds();
    t_read_hold();
    t_clear();
    t_b2b_same();
    t_b2b_diff();
    t_write_after_hit();
    t_write_with_hit();
    t_write_other();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule